// File: doc/BRIEF.md
# Render Completion Interrupt Unit

This block collects two completion events from a rendering pipeline and turns them into two separate interrupt lines. A "token" event reports that the pipeline reached a marker in its command stream and carries a 16-bit marker value. A "finish" event reports that a drawing pass has completed. Each event has a sticky pending flag and an enable. A pending flag is set by its event whatever its enable is. Its interrupt line is driven only while the enable is also set.

Software reaches the unit through a small register port: one write strobe, an address, write data and combinational read data. Address 0 is the control/status word, which holds the two enables and the two pending flags. A flag is acknowledged by writing it back as 1. Address 1 is the marker register: software zeroes it during setup, and each token event overwrites it with the event's value. The event inputs are single-cycle pulses with no back-pressure, because the pipeline never waits on this unit. The register port is plain and accepts a write on every cycle.

Top module: `render_irq_unit`

## Requirements
- R1: After reset the enables, both pending flags and the marker register are 0, so both interrupt lines are low and every read returns 0.
- R2: At address 0, bit 0 is the token enable and bit 1 is the finish enable. A write to address 0 loads both from write data bits 0 and 1. Bits 15 to 4 of address 0 always read 0.
- R3: Address 0 bit 2 is the token pending flag and bit 3 is the finish pending flag. A pulse on an event input sets its flag on the next clock edge, whether or not its enable is set.
- R4: A write to address 0 clears a pending flag when the flag's write data bit is 1. When that bit is 0 the flag keeps its value.
- R5: If an event pulse arrives in the same cycle as a write that clears its flag, the flag stays set.
- R6: `irq_token` is high exactly while the token flag and the token enable are both set. `irq_finish` is high exactly while the finish flag and the finish enable are both set. Each line depends only on its own event.
- R7: On a token event the marker register (address 1) loads the 16-bit event value at the next edge. A finish event leaves it unchanged.
- R8: A write to address 1 loads the marker register, unless a token event arrives in the same cycle. In that case the event value is stored.
- R9: A single write of 0x000F to address 0 sets both enables and clears both pending flags in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register address: 0 is control/status, 1 is marker |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| token_evt | input | 1 | Token event pulse |
| token_val | input | 16 | Marker value carried with `token_evt` |
| finish_evt | input | 1 | Finish event pulse |
| irq_token | output | 1 | Token interrupt line |
| irq_finish | output | 1 | Finish interrupt line |

## Verification
Two pairs of actions can land in the same cycle. An event pulse can coincide with a software acknowledge of its own flag, and a token event can coincide with a software write to the marker register. Directed steps drive each pair together on purpose. The next read must show the flag still set and the marker holding the event value rather than the written word. Random traffic with dense events and writes produces many more such overlaps, and a bench-side model that gives the event priority judges every cycle.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  localparam int unsigned NUM_EVT   = 2;
  localparam int unsigned EVT_TOKEN = 0;
  localparam int unsigned EVT_FIN   = 1;
  // control/status word layout (decoded by software)
  localparam int unsigned EN_LSB    = 0;
  localparam int unsigned PEND_LSB  = 2;
  localparam int unsigned CSR_USED  = PEND_LSB + NUM_EVT;
  localparam logic        ADDR_CSR  = 1'b0;
  localparam logic        ADDR_MARK = 1'b1;
endpackage

// File: rtl/rirq_pend_bit.sv
module rirq_pend_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_event_beats_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> q_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/rirq_marker_reg.sv
module rirq_marker_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_i,
  input  logic [DATA_W-1:0] evt_val_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_val_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= '0;
    else if (evt_i) q_o <= evt_val_i;
    else if (wr_i)  q_o <= wr_val_i;
  end

  p_event_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> (q_o == $past(evt_val_i)));
  p_write_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !evt_i) |=> (q_o == $past(wr_val_i)));
endmodule

// File: rtl/render_irq_unit.sv
module render_irq_unit
  import rirq_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              token_evt,
  input  logic [DATA_W-1:0] token_val,
  input  logic              finish_evt,
  output logic              irq_token,
  output logic              irq_finish
);
  localparam int unsigned PAD_W = DATA_W - CSR_USED;

  logic               csr_wr, mark_wr;
  logic [NUM_EVT-1:0] en_q, evt, clr, pend;
  logic [DATA_W-1:0]  mark_q;

  assign csr_wr  = bus_wr && (bus_addr == ADDR_CSR);
  assign mark_wr = bus_wr && (bus_addr == ADDR_MARK);

  assign evt[EVT_TOKEN] = token_evt;
  assign evt[EVT_FIN]   = finish_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)      en_q <= '0;
    else if (csr_wr) en_q <= bus_wdata[EN_LSB +: NUM_EVT];
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_pend
    assign clr[g] = csr_wr && bus_wdata[PEND_LSB + g];
    rirq_pend_bit u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(evt[g]),
      .clr_i(clr[g]),
      .q_o  (pend[g])
    );
  end

  rirq_marker_reg #(.DATA_W(DATA_W)) u_mark (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (token_evt),
    .evt_val_i(token_val),
    .wr_i     (mark_wr),
    .wr_val_i (bus_wdata),
    .q_o      (mark_q)
  );

  assign irq_token  = pend[EVT_TOKEN] & en_q[EVT_TOKEN];
  assign irq_finish = pend[EVT_FIN]   & en_q[EVT_FIN];

  always_comb begin
    if (bus_addr == ADDR_MARK) bus_rdata = mark_q;
    else                       bus_rdata = {{PAD_W{1'b0}}, pend, en_q};
  end

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_CSR) |-> (bus_rdata[DATA_W-1:CSR_USED] == '0));
  p_fin_event_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && en_q[EVT_FIN] && !csr_wr) |=> irq_finish);
  p_token_event_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (token_evt && en_q[EVT_TOKEN] && !csr_wr) |=> irq_token);
  p_setup_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && bus_wdata[3:0] == 4'hF && !token_evt && !finish_evt)
      |=> (en_q == 2'b11 && pend == 2'b00));
endmodule

// File: tb/render_irq_unit_bench.sv
`timescale 1ns/1ps
module render_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        token_evt = 1'b0, finish_evt = 1'b0;
  logic [15:0] token_val = '0;
  logic        irq_token, irq_finish;

  int unsigned n_cmp = 0, n_bad = 0;

  // bench model
  logic [1:0]  m_en = '0;
  logic        m_pt = 1'b0, m_pf = 1'b0;
  logic [15:0] m_mark = '0;

  always #5 clk = ~clk;

  render_irq_unit u_render_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .token_evt(token_evt),
    .token_val(token_val), .finish_evt(finish_evt),
    .irq_token(irq_token), .irq_finish(irq_finish)
  );

  function automatic logic [15:0] exp_read(input logic a);
    return a ? m_mark : {12'h000, m_pf, m_pt, m_en};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare current state, advance model
  task automatic cyc(input logic wr, input logic a, input logic [15:0] wd,
                     input logic te, input logic [15:0] tv, input logic fe);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd;
    token_evt = te; token_val = tv; finish_evt = fe;
    #1;
    if (a == 1'b0) begin
      check("R2 enables", {14'd0, bus_rdata[1:0]}, {14'd0, m_en});
      check("R3 pending", {14'd0, bus_rdata[3:2]}, {14'd0, m_pf, m_pt});
      check("R2 upper bits", {4'd0, bus_rdata[15:4]}, 16'd0);
    end else begin
      check("R7 marker", bus_rdata, m_mark);
    end
    check("R6 irq_token", {15'd0, irq_token}, {15'd0, m_pt & m_en[0]});
    check("R6 irq_finish", {15'd0, irq_finish}, {15'd0, m_pf & m_en[1]});
    // next state per R2..R8
    if (te) m_pt = 1'b1;
    else if (wr && !a && wd[2]) m_pt = 1'b0;
    if (fe) m_pf = 1'b1;
    else if (wr && !a && wd[3]) m_pf = 1'b0;
    if (wr && !a) m_en = wd[1:0];
    if (te) m_mark = tv;
    else if (wr && a) m_mark = wd;
  endtask

  task automatic peek(input string tag, input logic a, input logic [15:0] exp);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a; token_evt = 1'b0; finish_evt = 1'b0;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    peek("R1 csr after reset", 1'b0, 16'h0000);
    peek("R1 marker after reset", 1'b1, 16'h0000);
    check("R1 irq_token", {15'd0, irq_token}, 16'd0);
    check("R1 irq_finish", {15'd0, irq_finish}, 16'd0);

    // R3: events set flags with enables off, no interrupts
    cyc(1'b0, 1'b0, 16'h0, 1'b1, 16'hBEEF, 1'b1);
    peek("R3 flags set while disabled", 1'b0, 16'h000C);
    check("R6 no irq when disabled", {14'd0, irq_finish, irq_token}, 16'd0);
    // R7 marker loaded
    peek("R7 marker loaded", 1'b1, 16'hBEEF);
    // finish event leaves marker
    cyc(1'b0, 1'b0, 16'h0, 1'b0, 16'h1111, 1'b1);
    peek("R7 finish keeps marker", 1'b1, 16'hBEEF);

    // R4: write 0 to pending keeps, write 1 clears only that bit
    cyc(1'b1, 1'b0, 16'h0000, 1'b0, 16'h0, 1'b0);
    peek("R4 zero write keeps flags", 1'b0, 16'h000C);
    cyc(1'b1, 1'b0, 16'h0004, 1'b0, 16'h0, 1'b0);
    peek("R4 token flag cleared", 1'b0, 16'h0008);

    // R9 setup word
    cyc(1'b1, 1'b0, 16'h000F, 1'b0, 16'h0, 1'b0);
    peek("R9 setup word", 1'b0, 16'h0003);
    cyc(1'b1, 1'b1, 16'h0000, 1'b0, 16'h0, 1'b0);
    peek("R9 marker zeroed", 1'b1, 16'h0000);

    // R6 interrupt lines separate
    cyc(1'b0, 1'b0, 16'h0, 1'b1, 16'h00A5, 1'b0);
    peek("R6 token only", 1'b0, 16'h0007);
    check("R6 token line only", {14'd0, irq_finish, irq_token}, 16'h0001);

    // R5 event beats clear in the same cycle
    cyc(1'b1, 1'b0, 16'h000F, 1'b1, 16'h0123, 1'b1);
    peek("R5 flags survive clear", 1'b0, 16'h000F);
    check("R5 both lines high", {14'd0, irq_finish, irq_token}, 16'h0003);

    // R8 write vs event collision, then plain write
    cyc(1'b1, 1'b1, 16'hDEAD, 1'b1, 16'h4242, 1'b0);
    peek("R8 event wins marker", 1'b1, 16'h4242);
    cyc(1'b1, 1'b1, 16'h5A5A, 1'b0, 16'h0, 1'b0);
    peek("R8 plain marker write", 1'b1, 16'h5A5A);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0] & r[1], r[2], (r[3] ? 16'h000F : 16'($urandom)),
          r[4] & r[5], 16'($urandom), r[6] & r[7]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule